// File: doc/BRIEF.md
# I2C Slave Address Watcher

This block is the receive front end of an I2C slave. It samples the SCL and SDA lines on the system clock and finds start and stop conditions. After each start it shifts in the first byte on rising SCL edges and counts the serial clocks. It then checks that byte against a programmable own-address value and against the two extension-code groups.

When the address matches, the block pulls SDA low for the acknowledge clock. When the address matches or an extension code arrives, it raises a one-cycle interrupt request. A select input places that request on the falling edge of either the 8th or the 9th SCL clock. A stop condition can also raise the request, if that is enabled.

The flags stay valid for software or a downstream controller until the next start or stop. Clock stretching, master operation and transmit data are not part of this block.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset `irq`, `addr_hit`, `ext_code` and `sda_pull` are 0 and `rx_byte` is 0x00.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start, including a repeated start in the middle of a byte, clears the clock count and the partly received byte, so the next full byte is received correctly.
- R3: The first byte after a start is shifted in MSB first, one bit per SCL rising edge. `rx_byte` holds the complete byte from the falling edge of the 8th clock onward.
- R4: `addr_hit` is set at the 8th clock falling edge when `rx_byte[7:1]` equals `own_addr[7:1]`. `own_addr[0]` has no effect on matching.
- R5: `ext_code` is set when the upper four bits of the byte are 0000 or 1111. This raises an interrupt even when the address does not match.
- R6: With `wait_ninth`=0 the byte interrupt fires on the falling edge of the 8th SCL clock. With `wait_ninth`=1 it fires on the falling edge of the 9th.
- R7: A detected stop raises an interrupt only when `stop_irq_en`=1.
- R8: `sda_pull` is 1 from the 8th clock falling edge to the 9th clock falling edge, and only for an address match. It is not asserted for an extension code that does not match.
- R9: `irq` is a single-cycle pulse. `addr_hit` and `ext_code` hold after the byte until the next start or stop, which clears them.
- R10: A byte that neither matches nor is an extension code raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| own_addr | input | 8 | Own slave address in bits 7..1, bit 0 ignored |
| wait_ninth | input | 1 | 0: interrupt at 8th clock fall, 1: at 9th clock fall |
| stop_irq_en | input | 1 | Enables the interrupt on stop detection |
| irq | output | 1 | One-cycle interrupt request pulse |
| addr_hit | output | 1 | First byte matched the own address |
| ext_code | output | 1 | First byte was an extension code |
| rx_byte | output | 8 | Received first byte |
| sda_pull | output | 1 | Drive SDA low (acknowledge) |

## Verification
Each line passes through two synchronizer flops before edge detection, and the flag and interrupt registers add one more. Every result therefore appears three system clocks after the SCL or SDA change that causes it. The bench holds each bus phase for twelve clocks and samples flags and `sda_pull` only at the end of a phase, well past that latency. For interrupts, the driver records which event it has just produced (8th fall, 9th fall or stop) and queues the expected event. The monitor pops the queue on every `irq` pulse and compares the two, so a pulse in the wrong phase, an extra pulse or a missing one is reported.

// File: rtl/i2c_sa_pkg.sv
package i2c_sa_pkg;

    localparam int BYTE_W  = 8;
    localparam int ACK_CLK = BYTE_W + 1;
    localparam int CNT_W   = $clog2(ACK_CLK + 1);

    localparam logic [CNT_W-1:0] CNT_BYTE_DONE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK_DONE  = CNT_W'(ACK_CLK);

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_ACK
    } rx_state_e;

    function automatic logic addr_equal(input logic [BYTE_W-1:0] rx,
                                        input logic [BYTE_W-1:0] own);
        return rx[BYTE_W-1:1] == own[BYTE_W-1:1];
    endfunction

    function automatic logic is_ext_code(input logic [BYTE_W-1:0] rx);
        return (rx[BYTE_W-1 -: 4] == 4'h0) || (rx[BYTE_W-1 -: 4] == 4'hF);
    endfunction

endpackage

// File: rtl/i2c_sa_sync.sv
module i2c_sa_sync
    import i2c_sa_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.rise  = chain[STAGES-1] & ~chain[STAGES];
        ev.fall  = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/i2c_sa_cond.sv
module i2c_sa_cond
    import i2c_sa_pkg::*;
(
    input  line_ev_t  scl,
    input  line_ev_t  sda,
    output bus_cond_t cond
);
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl.level & ~scl.rise;
        cond.start      = sda.fall & scl_steady_high;
        cond.stop       = sda.rise & scl_steady_high;
    end

endmodule

// File: rtl/i2c_sa_shift.sv
module i2c_sa_shift
    import i2c_sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_cond_t         cond,
    input  line_ev_t          scl,
    input  logic              sda_bit,
    output logic [BYTE_W-1:0] data,
    output logic              eighth_fall,
    output logic              ninth_fall
);
    rx_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            data  <= '0;
        end else if (cond.start) begin
            state <= RX_SHIFT;
            cnt   <= '0;
            data  <= '0;
        end else if (cond.stop) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                RX_SHIFT: begin
                    if (scl.rise && cnt < CNT_BYTE_DONE) begin
                        data <= {data[BYTE_W-2:0], sda_bit};
                        cnt  <= cnt + CNT_W'(1);
                    end
                    if (scl.fall && cnt == CNT_BYTE_DONE) begin
                        state <= RX_ACK;
                    end
                end
                RX_ACK: begin
                    if (scl.rise && cnt < CNT_ACK_DONE) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                    if (scl.fall && cnt == CNT_ACK_DONE) begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        eighth_fall = (state == RX_SHIFT) && scl.fall && (cnt == CNT_BYTE_DONE);
        ninth_fall  = (state == RX_ACK) && scl.fall && (cnt == CNT_ACK_DONE);
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_ACK_DONE); // R3

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        cond.start |=> (cnt == '0 && state == RX_SHIFT && data == '0)); // R2

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
    import i2c_sa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              wait_ninth,
    input  logic              stop_irq_en,
    output logic              irq,
    output logic              addr_hit,
    output logic              ext_code,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_pull
);
    line_ev_t  scl_ev;
    line_ev_t  sda_ev;
    bus_cond_t cond;
    logic      eighth_fall;
    logic      ninth_fall;
    logic      match_now;
    logic      ext_now;

    i2c_sa_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk (clk),
        .rst (rst),
        .din (scl_in),
        .ev  (scl_ev)
    );

    i2c_sa_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk (clk),
        .rst (rst),
        .din (sda_in),
        .ev  (sda_ev)
    );

    i2c_sa_cond u_cond (
        .scl  (scl_ev),
        .sda  (sda_ev),
        .cond (cond)
    );

    i2c_sa_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .cond        (cond),
        .scl         (scl_ev),
        .sda_bit     (sda_ev.level),
        .data        (rx_byte),
        .eighth_fall (eighth_fall),
        .ninth_fall  (ninth_fall)
    );

    always_comb begin
        match_now = addr_equal(rx_byte, own_addr);
        ext_now   = is_ext_code(rx_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            addr_hit <= 1'b0;
            ext_code <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cond.start || cond.stop) begin
                addr_hit <= 1'b0;
                ext_code <= 1'b0;
                sda_pull <= 1'b0;
                if (cond.stop && stop_irq_en) begin
                    irq <= 1'b1;
                end
            end else if (eighth_fall) begin
                addr_hit <= match_now;
                ext_code <= ext_now;
                sda_pull <= match_now;
                if (!wait_ninth && (match_now || ext_now)) begin
                    irq <= 1'b1;
                end
            end else if (ninth_fall) begin
                sda_pull <= 1'b0;
                if (wait_ninth && (addr_hit || ext_code)) begin
                    irq <= 1'b1;
                end
            end
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9

    AST_PULL_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> addr_hit); // R8

    AST_PULL_STARTS_AT_EIGHTH: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(eighth_fall)); // R8

    AST_STOP_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        cond.stop |=> (!addr_hit && !ext_code && !sda_pull)); // R9

    AST_STOP_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (cond.stop && !stop_irq_en) |=> !irq); // R7

endmodule

// File: tb/test_i2c_addr_watch.sv
module test_i2c_addr_watch;

    localparam int PH        = 12;
    localparam int TAG_EIGHT = 8;
    localparam int TAG_NINE  = 9;
    localparam int TAG_STOP  = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [7:0] own_addr = 8'h00;
    logic       wait_ninth = 1'b0;
    logic       stop_irq_en = 1'b0;
    logic       irq, addr_hit, ext_code, sda_pull;
    logic [7:0] rx_byte;
    logic       sda_line;

    int total = 0;
    int bad   = 0;
    int cur_tag = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    i2c_addr_watch i_i2c_addr_watch (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_drv),
        .sda_in      (sda_line),
        .own_addr    (own_addr),
        .wait_ninth  (wait_ninth),
        .stop_irq_en (stop_irq_en),
        .irq         (irq),
        .addr_hit    (addr_hit),
        .ext_code    (ext_code),
        .rx_byte     (rx_byte),
        .sda_pull    (sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ph();
        repeat (PH) @(negedge clk);
    endtask

    // monitor: scoreboard for interrupt pulses (R6, R7, R9, R10)
    always @(negedge clk) begin
        if (!rst && irq) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected irq", cur_tag, -1);
            end else begin
                chk("R6/R7 irq event", cur_tag, exp_q.pop_front());
            end
        end
    end

    task automatic do_start();
        sda_drv = 1'b1; ph();
        scl_drv = 1'b1; ph();
        sda_drv = 1'b0; cur_tag = 0; ph();
        scl_drv = 1'b0; ph();
    endtask

    task automatic do_stop();
        sda_drv = 1'b0; ph();
        scl_drv = 1'b1; ph();
        if (stop_irq_en) exp_q.push_back(TAG_STOP);
        cur_tag = TAG_STOP;
        sda_drv = 1'b1; ph();
        chk("R9 addr_hit cleared by stop", addr_hit, 0);
        chk("R9 ext_code cleared by stop", ext_code, 0);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_drv = b[7-i]; ph();
            scl_drv = 1'b1; ph();
            cur_tag = i + 1;
            scl_drv = 1'b0; ph();
        end
    endtask

    task automatic send_addr(input logic [7:0] b);
        bit hit, ext;
        hit = (b[7:1] == own_addr[7:1]);
        ext = (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
        if (hit || ext) exp_q.push_back(wait_ninth ? TAG_NINE : TAG_EIGHT);
        send_bits(b, 8);
        chk("R3 rx_byte", rx_byte, b);
        chk("R4 addr_hit", addr_hit, hit);
        chk("R5 ext_code", ext_code, ext);
        chk("R8 sda_pull after 8th fall", sda_pull, hit);
        sda_drv = 1'b1; ph();
        scl_drv = 1'b1; ph();
        chk("R8 sda_pull in 9th clock", sda_pull, hit);
        cur_tag = TAG_NINE;
        scl_drv = 1'b0; ph();
        chk("R8 sda_pull released", sda_pull, 0);
        chk("R9 addr_hit held", addr_hit, hit);
        chk("R9 ext_code held", ext_code, ext);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 addr_hit", addr_hit, 0);
        chk("R1 ext_code", ext_code, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 rx_byte", rx_byte, 0);

        own_addr = 8'hA4; wait_ninth = 1'b0; stop_irq_en = 1'b1;
        do_start(); send_addr(8'hA4); do_stop();   // R4 R6 R7

        wait_ninth = 1'b1;
        do_start(); send_addr(8'hA5); do_stop();   // R6 9th fall

        own_addr = 8'hA5; stop_irq_en = 1'b0;
        do_start(); send_addr(8'hA4); do_stop();   // R4 bit0 ignored, R7 disabled

        do_start(); send_addr(8'h3C); do_stop();   // R10

        stop_irq_en = 1'b1;
        do_start(); send_addr(8'h0A); do_stop();   // R5 R8

        wait_ninth = 1'b0;
        do_start(); send_addr(8'hF2); do_stop();   // R5 upper group

        do_start(); send_bits(8'hE0, 3);           // R2 repeated start mid-byte
        do_start(); send_addr(8'hA4); do_stop();

        ph();
        chk("R6 all expected irqs seen", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule